// File: doc/BRIEF.md
# Gated JTAG TAP controller

This block is a test access port controller for a core that sits behind a chip-level test linking module. It follows the standard sixteen-state JTAG sequence, advanced on each rising edge of the test clock by the mode-select input. It holds a four-bit instruction register and a one-bit bypass register, and it shifts serial data out of the test-data output. That output is enabled only while a register is being shifted.

A chip-level enable input gates the mode-select input. While the enable is low, every rising edge sends the controller to Run-Test/Idle, whatever mode-select does. The controller can reach the data-register or instruction-register branches only while the enable is high. One instruction code raises a select output, which routes the data-register scan to an external chip-level register. In that case the serial input is forwarded on a scan-out pin and the serial output is taken from a scan-in pin. An active-low asynchronous reset forces the controller to Test-Logic-Reset at once.

Top module: `gated_tap`

## Requirements
- R1: Driving `trst_n` low immediately puts the controller in Test-Logic-Reset and loads the BYPASS instruction (4'b1111), with no test-clock edge needed. While it is low, `tdo_oe`, `tdo`, `ext_sel` and `ext_shift` are 0.
- R2: `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR, and it changes on the falling edge of `tck`. While `tdo_oe` is 0, `tdo` is held at 0.
- R3: When `tap_en` is low at a rising edge of `tck`, the next state is Run-Test/Idle from any state, whatever the value of `tms`.
- R4: When `tap_en` is low while the controller is in Update-DR, the next state is Run-Test/Idle, not Select-DR-Scan.
- R5: While `tap_en` is high, the state follows the standard sixteen-state JTAG transition table, sampling `tms` on the rising edge of `tck`. This includes holding in Test-Logic-Reset, Run-Test/Idle, Shift and Pause.
- R6: Capture-IR loads 4'b0001 into the instruction shifter. Shift-IR moves `tdi` in at the most significant bit and presents the least significant bit on `tdo` at the falling edge. The new instruction takes effect when the controller leaves Update-IR.
- R7: The one-bit bypass register captures 0 in Capture-DR and is loaded from `tdi` on each rising edge in Shift-DR, so `tdo` repeats `tdi` one clock later. It is the data register for BYPASS (4'b1111) and for every code other than the external-select code.
- R8: `ext_sel` is 1 exactly when the current instruction is the external-select code, 4'b0101. While `ext_sel` is 1 and the state is Shift-DR, `ext_shift` is 1 and `ext_tdi` equals `tdi`, otherwise both are 0. `tdo` takes the value of `ext_tdo` at each falling edge.
- R9: With `tap_en` high, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state.
- R10: Each rising edge taken in Test-Logic-Reset loads the BYPASS instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset to Test-Logic-Reset |
| tap_en | input | 1 | Chip-level enable; low forces Run-Test/Idle |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| ext_tdo | input | 1 | Serial return from the external chip-level register |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`, high in the shift states |
| ext_sel | output | 1 | External chip-level register selected by the instruction |
| ext_shift | output | 1 | External register shifting (Shift-DR with `ext_sel`) |
| ext_tdi | output | 1 | Serial data forwarded to the external register |

## Verification
Each state move takes effect at a rising edge of `tck`. `tdo` and `tdo_oe` follow half a cycle later, at the next falling edge. A bypassed bit reappears on `tdo` one full cycle after it enters on `tdi`. A new instruction changes `ext_sel` at the edge that leaves Update-IR. `ext_shift` and `ext_tdi` follow the current state and `tdi` with no register in the path. The bench drives every input 1 ns after a falling edge and advances a behavioural model at each rising edge. It predicts `tdo` and `tdo_oe` at the falling edge and compares all outputs 1 ns after the next drive, which is well away from both clock edges. The asynchronous reset is checked 1 ns after `trst_n` falls, with no clock edge in between.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'h0,
    ST_IDLE     = 4'h1,
    ST_DR_SEL   = 4'h2,
    ST_DR_CAP   = 4'h3,
    ST_DR_SHIFT = 4'h4,
    ST_DR_EXIT1 = 4'h5,
    ST_DR_PAUSE = 4'h6,
    ST_DR_EXIT2 = 4'h7,
    ST_DR_UPD   = 4'h8,
    ST_IR_SEL   = 4'h9,
    ST_IR_CAP   = 4'hA,
    ST_IR_SHIFT = 4'hB,
    ST_IR_EXIT1 = 4'hC,
    ST_IR_PAUSE = 4'hD,
    ST_IR_EXIT2 = 4'hE,
    ST_IR_UPD   = 4'hF
  } tap_state_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tap_en,
  input  logic       tms,
  output tap_state_e state_q
);

  tap_state_e state_d;

  // Next-state: enable low parks the controller in Run-Test/Idle
  always_comb begin
    state_d = state_q;
    if (!tap_en) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
        ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
        ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
        ST_DR_CAP:   state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
        ST_DR_SHIFT: state_d = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
        ST_DR_EXIT1: state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
        ST_DR_PAUSE: state_d = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
        ST_DR_EXIT2: state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
        ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
        ST_IR_CAP:   state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
        ST_IR_SHIFT: state_d = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
        ST_IR_EXIT1: state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
        ST_IR_PAUSE: state_d = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
        ST_IR_EXIT2: state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
        ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
        default:     state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      state_q <= ST_RESET;
    end else begin
      state_q <= state_d;
    end
  end

  p_en_low_idle_r3: assert property (@(posedge tck) disable iff (!trst_n)
    !tap_en |=> (state_q == ST_IDLE))
    else $error("enable low did not park in Run-Test/Idle");

  p_upd_dr_idle_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_DR_UPD && !tap_en) |=> (state_q == ST_IDLE))
    else $error("Update-DR with enable low did not return to idle");

  p_five_ones_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_en && tms && $past(tap_en && tms, 1) && $past(tap_en && tms, 2)
     && $past(tap_en && tms, 3) && $past(tap_en && tms, 4))
    |=> (state_q == ST_RESET))
    else $error("five high mode-select edges did not reach reset");

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W    = 4,
  parameter logic [IR_W-1:0] CAP_VAL = IR_W'(1),
  parameter logic [IR_W-1:0] EXT_OP  = IR_W'(5)
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state_q,
  input  logic       tdi,
  output logic       ir_so,
  output logic       ext_sel
);

  localparam logic [IR_W-1:0] BYPASS_OP = '1;

  logic [IR_W-1:0] sh_q, sh_d, ir_q, ir_d;
  logic            sh_en, ir_en;

  always_comb begin
    sh_en = (state_q == ST_IR_CAP) || (state_q == ST_IR_SHIFT);
    sh_d  = (state_q == ST_IR_CAP) ? CAP_VAL : {tdi, sh_q[IR_W-1:1]};
    ir_en = (state_q == ST_IR_UPD) || (state_q == ST_RESET);
    ir_d  = (state_q == ST_RESET) ? BYPASS_OP : sh_q;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q <= CAP_VAL;
      ir_q <= BYPASS_OP;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir_so   = sh_q[0];
  assign ext_sel = (ir_q == EXT_OP);

  p_capture_ir_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_IR_CAP) |=> (sh_q == CAP_VAL))
    else $error("Capture-IR value wrong");

  p_reset_bypass_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET) |=> (ir_q == BYPASS_OP))
    else $error("Test-Logic-Reset did not load BYPASS");

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state_q,
  input  logic       tdi,
  input  logic       ir_so,
  input  logic       ext_sel,
  input  logic       ext_tdo,
  output logic       tdo,
  output logic       tdo_oe,
  output logic       ext_shift,
  output logic       ext_tdi
);

  logic byp_q, byp_d, byp_en;
  logic out_d, oe_d;

  always_comb begin
    byp_en = (state_q == ST_DR_CAP) || (state_q == ST_DR_SHIFT);
    byp_d  = (state_q == ST_DR_SHIFT) ? tdi : 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
    end else if (byp_en) begin
      byp_q <= byp_d;
    end
  end

  assign ext_shift = ext_sel && (state_q == ST_DR_SHIFT);
  assign ext_tdi   = tdi & ext_shift;

  // Output retiming: selected serial source, held low outside shifts
  always_comb begin
    oe_d  = 1'b0;
    out_d = 1'b0;
    case (state_q)
      ST_IR_SHIFT: begin
        oe_d  = 1'b1;
        out_d = ir_so;
      end
      ST_DR_SHIFT: begin
        oe_d  = 1'b1;
        out_d = ext_sel ? ext_tdo : byp_q;
      end
      default: begin
        oe_d  = 1'b0;
        out_d = 1'b0;
      end
    endcase
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= out_d;
      tdo_oe <= oe_d;
    end
  end

  p_oe_shift_only_r2: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state_q == ST_IR_SHIFT) || (state_q == ST_DR_SHIFT)))
    else $error("tdo_oe outside shift states");

  p_bypass_capture_r7: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_DR_CAP) |=> (byp_q == 1'b0))
    else $error("bypass did not capture zero");

endmodule

// File: rtl/gated_tap.sv
module gated_tap
  import tap_pkg::*;
#(
  parameter int              IR_W    = 4,
  parameter logic [IR_W-1:0] CAP_VAL = IR_W'(1),
  parameter logic [IR_W-1:0] EXT_OP  = IR_W'(5)
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tap_en,
  input  logic tms,
  input  logic tdi,
  input  logic ext_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic ext_sel,
  output logic ext_shift,
  output logic ext_tdi
);

  tap_state_e state_q;
  logic       ir_so;

  tap_fsm u_fsm (
    .tck     (tck),
    .trst_n  (trst_n),
    .tap_en  (tap_en),
    .tms     (tms),
    .state_q (state_q)
  );

  tap_ir #(
    .IR_W    (IR_W),
    .CAP_VAL (CAP_VAL),
    .EXT_OP  (EXT_OP)
  ) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .state_q (state_q),
    .tdi     (tdi),
    .ir_so   (ir_so),
    .ext_sel (ext_sel)
  );

  tap_dr u_dr (
    .tck       (tck),
    .trst_n    (trst_n),
    .state_q   (state_q),
    .tdi       (tdi),
    .ir_so     (ir_so),
    .ext_sel   (ext_sel),
    .ext_tdo   (ext_tdo),
    .tdo       (tdo),
    .tdo_oe    (tdo_oe),
    .ext_shift (ext_shift),
    .ext_tdi   (ext_tdi)
  );

endmodule

// File: tb/sim_gated_tap.sv
module sim_gated_tap;

  logic tck = 1'b0;
  logic trst_n, tap_en, tms, tdi, ext_tdo;
  logic tdo, tdo_oe, ext_sel, ext_shift, ext_tdi;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 tck = ~tck;  // 125 MHz

  gated_tap u0 (
    .tck(tck), .trst_n(trst_n), .tap_en(tap_en), .tms(tms), .tdi(tdi),
    .ext_tdo(ext_tdo), .tdo(tdo), .tdo_oe(tdo_oe), .ext_sel(ext_sel),
    .ext_shift(ext_shift), .ext_tdi(ext_tdi)
  );

  // Behavioural model: state numbering of the bench's own
  localparam int M_TLR = 10, M_RTI = 11, M_SDR = 20, M_CDR = 21, M_SHD = 22,
                 M_E1D = 23, M_PD = 24, M_E2D = 25, M_UD = 26,
                 M_SIR = 30, M_CIR = 31, M_SHI = 32, M_E1I = 33, M_PI = 34,
                 M_E2I = 35, M_UI = 36;
  localparam logic [3:0] EXT_CODE = 4'b0101;

  int         m_st;
  logic [3:0] m_ir, m_irsh;
  logic       m_byp, m_tdo, m_oe;
  string      m_tag;

  function automatic int next_of(int s, bit m);
    case (s)
      M_TLR: return m ? M_TLR : M_RTI;
      M_RTI: return m ? M_SDR : M_RTI;
      M_SDR: return m ? M_SIR : M_CDR;
      M_CDR, M_SHD: return m ? M_E1D : M_SHD;
      M_E1D: return m ? M_UD : M_PD;
      M_PD:  return m ? M_E2D : M_PD;
      M_E2D: return m ? M_UD : M_SHD;
      M_SIR: return m ? M_TLR : M_CIR;
      M_CIR, M_SHI: return m ? M_E1I : M_SHI;
      M_E1I: return m ? M_UI : M_PI;
      M_PI:  return m ? M_E2I : M_PI;
      M_E2I: return m ? M_UI : M_SHI;
      M_UD, M_UI: return m ? M_SDR : M_RTI;
      default: return M_TLR;
    endcase
  endfunction

  task automatic model_reset();
    m_st = M_TLR; m_ir = 4'hF; m_irsh = 4'h1; m_byp = 0;
    m_tdo = 0; m_oe = 0; m_tag = "R2";
  endtask

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
    end
  endtask

  // One test-clock cycle; entered and left 1 ns after a falling edge
  task automatic tick(bit m, bit d, bit e, bit x);
    bit esel, eshift;
    tms = m; tdi = d; tap_en = e; ext_tdo = x;
    #1;
    esel   = (m_ir == EXT_CODE);
    eshift = esel && (m_st == M_SHD);
    chk("R2", tdo_oe, m_oe);
    chk(m_tag, tdo, m_tdo);
    chk("R8", ext_sel, esel);
    chk("R8", ext_shift, eshift);
    chk("R8", ext_tdi, eshift ? d : 1'b0);
    @(posedge tck);
    case (m_st)
      M_TLR: m_ir = 4'hF;
      M_CIR: m_irsh = 4'b0001;
      M_SHI: m_irsh = {d, m_irsh[3:1]};
      M_UI:  m_ir = m_irsh;
      M_CDR: m_byp = 0;
      M_SHD: m_byp = d;
      default: ;
    endcase
    m_st = e ? next_of(m_st, m) : M_RTI;
    @(negedge tck);
    if (m_st == M_SHI) begin
      m_oe = 1; m_tdo = m_irsh[0]; m_tag = "R6";
    end else if (m_st == M_SHD) begin
      m_oe = 1;
      if (m_ir == EXT_CODE) begin m_tdo = x; m_tag = "R8"; end
      else begin m_tdo = m_byp; m_tag = "R7"; end
    end else begin
      m_oe = 0; m_tdo = 0; m_tag = "R2";
    end
    #1;
  endtask

  task automatic go(bit m, bit d);
    tick(m, d, 1'b1, 1'b0);
  endtask

  task automatic load_ir(logic [3:0] v);
    go(1, 0); go(1, 0); go(0, 0); go(0, 0);
    for (int i = 0; i < 4; i++) go(i == 3, v[i]);
    go(1, 0); go(0, 0);
  endtask

  task automatic to_shift_dr();
    go(1, 0); go(0, 0); go(0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    trst_n = 0; tap_en = 1; tms = 1; tdi = 0; ext_tdo = 0;
    model_reset();
    repeat (3) @(negedge tck);
    #1;
    chk("R1", tdo_oe, 1'b0); chk("R1", tdo, 1'b0); chk("R1", ext_sel, 1'b0);
    trst_n = 1;

    go(1, 0); go(1, 0);                                   // R5 hold in reset
    tick(1, 0, 0, 0); tick(1, 1, 0, 0); tick(0, 0, 0, 0); // R3 parked
    to_shift_dr();
    chk("R5", tdo_oe, 1'b1);
    go(0, 1); go(0, 0);
    tick(0, 1, 0, 0);                                     // R3 leave Shift-DR
    chk("R3", tdo_oe, 1'b0);

    to_shift_dr(); go(1, 0); go(1, 0);                    // now Update-DR
    tick(1, 0, 0, 0);                                     // R4
    go(0, 0); to_shift_dr();
    chk("R4", tdo_oe, 1'b1);
    go(1, 0); go(1, 0); go(0, 0);

    load_ir(EXT_CODE);                                    // R6 shift-out of 0001
    chk("R8", ext_sel, 1'b1);
    to_shift_dr();
    for (int i = 0; i < 6; i++) tick(i == 5, i[0], 1'b1, i[1]);
    go(1, 0); go(0, 0);

    to_shift_dr(); go(1, 0); go(0, 0); go(0, 0); go(1, 0); go(0, 1);
    chk("R5", tdo_oe, 1'b1);                              // via Pause-DR
    go(1, 0); go(1, 0); go(0, 0);

    to_shift_dr();
    for (int i = 0; i < 5; i++) go(1, 0);                 // R9
    go(1, 0);
    chk("R9", ext_sel, 1'b0);
    go(0, 0);

    load_ir(EXT_CODE);
    go(1, 0); go(1, 0); go(1, 0); go(1, 0);               // via Select-IR
    chk("R10", ext_sel, 1'b0);
    go(0, 0);

    load_ir(4'b0011);                                     // unassigned code
    chk("R7", ext_sel, 1'b0);
    to_shift_dr();
    chk("R7", tdo, 1'b0);
    go(0, 1); go(0, 1); go(0, 0); go(0, 1); go(0, 0); go(1, 1);
    go(1, 0); go(0, 0);

    load_ir(4'b1111);
    to_shift_dr(); go(0, 1); go(0, 0); go(1, 1); go(1, 0); go(0, 0);

    load_ir(EXT_CODE);
    to_shift_dr(); tick(0, 1, 1, 1); tick(0, 0, 1, 1);
    trst_n = 0;                                           // R1 mid-shift
    #1;
    chk("R1", tdo_oe, 1'b0); chk("R1", tdo, 1'b0);
    chk("R1", ext_sel, 1'b0); chk("R1", ext_shift, 1'b0);
    model_reset();
    trst_n = 1;
    go(1, 0); go(0, 0); to_shift_dr(); go(0, 1);
    go(1, 0); go(1, 0); go(0, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule